// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Code Register Bank

This block holds the digital register state behind a four-channel voltage DAC. A serial front end delivers decoded commands, one per clock, each with an opcode, a per-channel select mask and a 12-bit code field. Every channel keeps two stages: a staged code that software fills in ahead of time, and a live code that drives the converter. Only the live code appears at the outputs.

Live codes can be updated in four ways. A command can write the staged and live stages together. A command can copy staged codes into live ones. An active-low load pin does the same copy for every channel enabled in a pin mask, and it keeps copying on each cycle for as long as it stays low. Software can also only stage a code. The block also keeps a 2-bit reference-source selection, and it registers a per-channel power-down request into a status output. Codes survive power-down. A power-on reset, an asynchronous clear pin, a software clear and a software reset each zero the codes. A software reset also restores the pin mask and the reference selection.

Top module: `dac_reg_bank`

## Requirements
- R1: After rst_n is released, every live code reads 0, ref_sel reads 0 (external), pd_status reads 0 and the load-pin mask enables all channels.
- R2: Opcode 0 (stage) writes the code into the staged register of each channel whose cmd_sel bit is 1, and no live code changes.
- R3: Opcode 1 (stage-and-apply) writes the code into both stages of each selected channel, and the new live code is visible after the clock edge that accepts the command.
- R4: Opcode 2 (apply) copies the staged code into the live code of each selected channel, and unselected channels keep their live code.
- R5: load_n passes through two synchronizing flops. From the third rising edge after it goes low, and on every edge while it stays low, each pin-enabled channel copies its staged code into its live code.
- R6: Opcode 3 loads the pin mask from cmd_sel (bit i = 1 lets channel i follow load_n), and a channel whose bit is 0 ignores load_n.
- R7: Opcode 4 loads ref_sel from cmd_data[1:0], with 0 = external, 1 = 2.048 V, 2 = 2.5 V and 3 = 4.096 V.
- R8: Opcode 5 (software clear) zeroes the staged and live codes of all channels and leaves the pin mask and ref_sel unchanged.
- R9: Opcode 6 (software reset) zeroes all codes, sets the pin mask to all ones and sets ref_sel to 0.
- R10: clr_n low zeroes all live and staged codes at once, without waiting for a clock edge. The clear is released on the third rising edge after clr_n returns high, and the pin mask and ref_sel are unaffected.
- R11: pd_status equals pd_req delayed by one clock. During power-down, codes are held and commands still update them, and when a channel powers back up its output shows the stored live code.
- R12: A code occupies cmd_data[11:12-N] (left-justified, N = 10 by default), and the 12-N low bits of the code field are ignored.
- R13: Opcode 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| clr_n | input | 1 | Asynchronous code clear, active low |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_sel | input | CH (4) | Channel select mask |
| cmd_data | input | CW (12) | Left-justified code field (ref code in bits 1:0) |
| load_n | input | 1 | Asynchronous active-low load pin |
| pd_req | input | CH (4) | Per-channel power-down request |
| dac_code | output | CH*N (40) | Live codes, channel i in bits [i*N +: N] |
| ref_sel | output | 2 | Reference source selection |
| pd_status | output | CH (4) | Registered power-down state |

## Verification
A bad staged code stays hidden until an apply command or the load pin exposes it. It then shows on dac_code on the following edge, or two edges later when the pin is the trigger. For this reason the random stimulus mixes stage, apply and pin activity densely. A wrong pin mask shows only through the load pin, and a wrong reference field appears on ref_sel one cycle after the command. A cycle-accurate bench model compares every output on every cycle, so any divergence is reported in the cycle it becomes visible.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  typedef enum logic [2:0] {
    OP_STAGE    = 3'd0,
    OP_STAGEAPP = 3'd1,
    OP_APPLY    = 3'd2,
    OP_PINMASK  = 3'd3,
    OP_REFSEL   = 3'd4,
    OP_SWCLEAR  = 3'd5,
    OP_SWRESET  = 3'd6,
    OP_NONE     = 3'd7
  } dac_op_e;

  typedef enum logic [1:0] {
    REF_EXT   = 2'd0,
    REF_2V048 = 2'd1,
    REF_2V500 = 2'd2,
    REF_4V096 = 2'd3
  } ref_src_e;
endpackage

// File: rtl/dacbank_rstsync.sv
module dacbank_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign srst_n = q2;
endmodule

// File: rtl/dacbank_sync2.sv
module dacbank_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacbank_pkg::*;
#(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [CH-1:0] cmd_sel,
  input  logic [1:0]    ref_bits,
  input  logic          pin_low,
  output logic [CH-1:0] wr_stage,
  output logic [CH-1:0] wr_live,
  output logic [CH-1:0] xfer,
  output logic          zero_all,
  output logic [1:0]    ref_q
);
  dac_op_e       op;
  logic          is_stage, is_sapp, is_apply, is_mask, is_ref, is_clr, is_rst;
  logic [CH-1:0] pin_en_q, pin_en_d;
  logic [1:0]    ref_d;
  logic          pin_en_ce, ref_ce;

  assign op = dac_op_e'(cmd_op);

  always_comb begin
    is_stage = cmd_valid && (op == OP_STAGE);
    is_sapp  = cmd_valid && (op == OP_STAGEAPP);
    is_apply = cmd_valid && (op == OP_APPLY);
    is_mask  = cmd_valid && (op == OP_PINMASK);
    is_ref   = cmd_valid && (op == OP_REFSEL);
    is_clr   = cmd_valid && (op == OP_SWCLEAR);
    is_rst   = cmd_valid && (op == OP_SWRESET);
  end

  always_comb begin
    wr_stage = (is_stage || is_sapp) ? cmd_sel : '0;
    wr_live  = is_sapp ? cmd_sel : '0;
    xfer     = (is_apply ? cmd_sel : '0) | (pin_low ? pin_en_q : '0);
    zero_all = is_clr || is_rst;
  end

  // next-state for pin mask and reference selection
  always_comb begin
    pin_en_ce = is_mask || is_rst;
    pin_en_d  = is_rst ? {CH{1'b1}} : cmd_sel;
    ref_ce    = is_ref || is_rst;
    ref_d     = is_rst ? REF_EXT : ref_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en_q <= {CH{1'b1}};
      ref_q    <= REF_EXT;
    end else begin
      if (pin_en_ce) pin_en_q <= pin_en_d;
      if (ref_ce)    ref_q    <= ref_d;
    end
  end

  p_swreset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> (ref_q == REF_EXT) && (pin_en_q == {CH{1'b1}}));

  p_refsel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> ref_q == $past(ref_bits));

  p_pinmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_mask |=> pin_en_q == $past(cmd_sel));

  p_swclear_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> $stable(ref_q) && $stable(pin_en_q));
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero,
  input  logic         we_stage,
  input  logic         we_live,
  input  logic         xfer,
  input  logic [N-1:0] din,
  output logic [N-1:0] live_q
);
  logic [N-1:0] stage_q, stage_d, live_d;
  logic         stage_ce, live_ce;

  always_comb begin
    stage_ce = zero || we_stage;
    stage_d  = zero ? '0 : din;
    live_ce  = zero || we_live || xfer;
    if (zero)         live_d = '0;
    else if (we_live) live_d = din;
    else              live_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (stage_ce) stage_q <= stage_d;
      if (live_ce)  live_q  <= live_d;
    end
  end

  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_stage && !zero) |=> $stable(stage_q));

  p_live_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_live && !zero) |=> live_q == $past(din));

  p_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !we_live && !zero) |=> live_q == $past(stage_q));

  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (live_q == '0) && (stage_q == '0));
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dacbank_pkg::*;
#(
  parameter int CH = 4,
  parameter int N  = 10,
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [CH-1:0]   cmd_sel,
  input  logic [CW-1:0]   cmd_data,
  input  logic            load_n,
  input  logic [CH-1:0]   pd_req,
  output logic [CH*N-1:0] dac_code,
  output logic [1:0]      ref_sel,
  output logic [CH-1:0]   pd_status
);
  localparam int LSB = CW - N;

  logic          sys_rst_n, code_rst_n, load_sync;
  logic [CH-1:0] wr_stage, wr_live, xfer, pd_d;
  logic          zero_all;
  logic [N-1:0]  code_in;

  dacbank_rstsync u_sys_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  dacbank_rstsync u_code_rst (
    .clk(clk), .arst_n(rst_n & clr_n), .srst_n(code_rst_n));

  dacbank_sync2 #(.RST_VAL(1'b1)) u_load_sync (
    .clk(clk), .rst_n(sys_rst_n), .d(load_n), .q(load_sync));

  assign code_in = cmd_data[CW-1:LSB];

  dacbank_ctrl #(.CH(CH)) u_ctrl (
    .clk(clk), .rst_n(sys_rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .ref_bits(cmd_data[1:0]), .pin_low(!load_sync),
    .wr_stage(wr_stage), .wr_live(wr_live), .xfer(xfer),
    .zero_all(zero_all), .ref_q(ref_sel));

  for (genvar i = 0; i < CH; i++) begin : g_chan
    dacbank_chan #(.N(N)) u_chan (
      .clk(clk), .rst_n(code_rst_n), .zero(zero_all),
      .we_stage(wr_stage[i]), .we_live(wr_live[i]), .xfer(xfer[i]),
      .din(code_in), .live_q(dac_code[i*N +: N]));
  end

  assign pd_d = pd_req;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) pd_status <= '0;
    else            pd_status <= pd_d;
  end

  p_clr_async_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == '0);

  p_op7_idle_r13: assert property (@(posedge clk) disable iff (!code_rst_n)
    (cmd_valid && cmd_op == 3'd7 && load_sync) |=> $stable(dac_code));
endmodule

// File: tb/sim_dac_reg_bank.sv
`timescale 1ns/1ps
module sim_dac_reg_bank;
  localparam int CH = 4, N = 10, CW = 12;
  localparam logic [2:0] STG = 0, SAP = 1, APP = 2, MSK = 3, REF = 4,
                         SCL = 5, SRS = 6, NOP7 = 7;

  logic clk = 1'b0;
  logic rst_n, clr_n, cmd_valid, load_n;
  logic [2:0]      cmd_op;
  logic [CH-1:0]   cmd_sel, pd_req;
  logic [CW-1:0]   cmd_data;
  logic [CH*N-1:0] dac_code;
  logic [1:0]      ref_sel;
  logic [CH-1:0]   pd_status;

  always #10 clk = ~clk;

  dac_reg_bank u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
    .load_n(load_n), .pd_req(pd_req), .dac_code(dac_code),
    .ref_sel(ref_sel), .pd_status(pd_status));

  int    nchk = 0, nbad = 0;
  string tag = "R1";

  // bench model built from the requirements
  logic [N-1:0]  m_stg [CH];
  logic [N-1:0]  m_live[CH];
  logic [CH-1:0] m_en, m_pd;
  logic [1:0]    m_ref;
  logic          m_s1, m_s2;
  int            m_clr_hold;

  function automatic logic [N-1:0] field(input logic [CW-1:0] d);
    return d[CW-1 -: N];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) begin m_stg[i] = '0; m_live[i] = '0; end
      m_en = '1; m_ref = 2'd0; m_pd = '0; m_s1 = 1'b1; m_s2 = 1'b1; m_clr_hold = 0;
    end else begin
      automatic logic blocked = !clr_n || (m_clr_hold > 0);
      automatic logic pin = !m_s2;
      automatic logic [CH-1:0] en_old = m_en;
      automatic logic zero = cmd_valid && (cmd_op == SCL || cmd_op == SRS);
      for (int i = 0; i < CH; i++) begin
        automatic logic sel = cmd_valid && cmd_sel[i];
        automatic logic [N-1:0] old_stg = m_stg[i];
        if (blocked || zero) begin
          m_stg[i] = '0; m_live[i] = '0;
        end else begin
          if (sel && (cmd_op == STG || cmd_op == SAP)) m_stg[i] = field(cmd_data);
          if (sel && cmd_op == SAP) m_live[i] = field(cmd_data);
          else if ((sel && cmd_op == APP) || (pin && en_old[i])) m_live[i] = old_stg;
        end
      end
      if (cmd_valid && cmd_op == MSK) m_en = cmd_sel;
      if (cmd_valid && cmd_op == REF) m_ref = cmd_data[1:0];
      if (cmd_valid && cmd_op == SRS) begin m_en = '1; m_ref = 2'd0; end
      m_pd = pd_req;
      m_s2 = m_s1; m_s1 = load_n;
      if (!clr_n) m_clr_hold = 2;
      else if (m_clr_hold > 0) m_clr_hold--;
    end
  end

  task automatic check_all();
    for (int i = 0; i < CH; i++) begin
      nchk++;
      if (dac_code[i*N +: N] !== m_live[i]) begin
        nbad++;
        $display("FAIL %s ch%0d code: actual %h expected %h", tag, i, dac_code[i*N +: N], m_live[i]);
      end
    end
    nchk++;
    if (ref_sel !== m_ref) begin
      nbad++;
      $display("FAIL %s ref_sel: actual %0d expected %0d", tag, ref_sel, m_ref);
    end
    nchk++;
    if (pd_status !== m_pd) begin
      nbad++;
      $display("FAIL %s pd_status: actual %b expected %b", tag, pd_status, m_pd);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); check_all(); end
  endtask

  task automatic issue(input logic [2:0] op, input logic [CH-1:0] sel, input logic [CW-1:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_data = d;
    @(negedge clk); check_all();
    cmd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    #4000000;
    nbad++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    rst_n = 0; clr_n = 1; cmd_valid = 0; cmd_op = 0; cmd_sel = 0;
    cmd_data = 0; load_n = 1; pd_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; idle(4);

    tag = "R2"; issue(STG, 4'b0101, 12'hABC); idle(1);
    tag = "R12"; issue(STG, 4'b1010, 12'hFFF); issue(STG, 4'b0001, 12'h003);
    tag = "R4"; issue(APP, 4'b1011, 12'h000); idle(1);
    issue(APP, 4'b0100, 12'h000); idle(1);
    tag = "R3"; issue(SAP, 4'b0010, 12'h5A4); idle(1);

    tag = "R5"; issue(STG, 4'b1111, 12'h7F0);
    load_n = 0; idle(4);
    issue(STG, 4'b0001, 12'h2C8); idle(2);
    load_n = 1; idle(3);

    tag = "R6"; issue(MSK, 4'b0011, 12'h000);
    issue(STG, 4'b1111, 12'h124);
    load_n = 0; idle(4); load_n = 1; idle(3);

    tag = "R7";
    issue(REF, 4'b0000, 12'h001); issue(REF, 4'b0000, 12'h002);
    issue(REF, 4'b0000, 12'h003); idle(1);

    tag = "R11"; pd_req = 4'b1111; idle(2);
    issue(SAP, 4'b0100, 12'h888); issue(STG, 4'b1000, 12'h444);
    issue(APP, 4'b1000, 12'h000); idle(1);
    pd_req = 4'b0000; idle(2);

    tag = "R13"; issue(NOP7, 4'b1111, 12'hFFF); idle(2);

    tag = "R8"; issue(SCL, 4'b1111, 12'h000); idle(1);
    issue(STG, 4'b1111, 12'h964);
    load_n = 0; idle(4); load_n = 1; idle(3);

    tag = "R9"; issue(SRS, 4'b0000, 12'h000); idle(1);
    issue(STG, 4'b1111, 12'h3B0);
    load_n = 0; idle(4); load_n = 1; idle(3);

    tag = "R10";
    #2 clr_n = 0;
    #3;
    nchk++;
    if (dac_code !== '0) begin
      nbad++;
      $display("FAIL R10 async clear: actual %h expected 0", dac_code);
    end
    for (int i = 0; i < CH; i++) begin m_stg[i] = '0; m_live[i] = '0; end
    idle(2);
    clr_n = 1; idle(4);

    tag = "RND";
    for (int k = 0; k < 3000; k++) begin
      automatic int r = $urandom_range(0, 99);
      cmd_valid = (r < 70);
      cmd_op    = (r < 2) ? SCL : (r < 3) ? SRS : 3'($urandom_range(0, 4));
      if (r >= 97) cmd_op = NOP7;
      cmd_sel   = 4'($urandom);
      cmd_data  = 12'($urandom);
      if ($urandom_range(0, 7) == 0) load_n = ~load_n;
      if ($urandom_range(0, 15) == 0) pd_req = 4'($urandom);
      @(negedge clk); check_all();
    end
    cmd_valid = 0; load_n = 1; idle(3);
    summary();
  end

  initial void'($urandom(32'd1234));
endmodule